// File: doc/BRIEF.md
# Latched BCD Seven-Segment Driver

This block turns a four-bit binary-coded decimal digit into the seven segment drive lines of a numeric readout. A capture control decides whether the digit is live or frozen. While the control is high the shown digit tracks the input. When the control falls, the last digit seen is kept and shown until the control rises again. Codes ten to fifteen are never drawn as partial shapes: they blank the digit. A separate blank input turns every segment off, whatever digit is stored.

A polarity stage can invert all seven lines together, so one block drives LEDs with a shared cathode, LEDs with a shared anode, or a liquid-crystal glass that needs AC drive. The polarity comes from one of four sources: the external polarity pin, a fixed low, a fixed high, or an internal divider. The divider makes a square wave with exactly 50 % duty. In that last mode the same register inverts the segments and drives the backplane output, so segments and backplane stay in step.

Every input passes through a two-flop synchronizer before use, and the outputs are registered. A change at the pins therefore appears on the outputs on the third rising clock edge.

Top module: `segdrv_top`

## Requirements
- R1: While `latchOpen` is high the displayed digit follows `digitIn`. While it is low, the code present when it was last high is held, and later `digitIn` changes have no effect on `segOut`.
- R2: Codes 10 to 15 drive all seven segments inactive, which is `7'b0000000` when the polarity is 0.
- R3: `blankIn` high drives all seven segments inactive, for any stored code.
- R4: With polarity 1 every bit of `segOut` is the inverse of the polarity-0 pattern, and the blank pattern is inverted too. With polarity 0 the pattern passes unchanged.
- R5: `digitIn` is 8421 BCD with bit 3 as the most significant bit. `segOut` bit 6 is segment a and bit 0 is segment g. The polarity-0 patterns for 0 to 9 are 7E, 30, 6D, 79, 33, 5B, 5F, 70, 7F, 7B (hex).
- R6: `phaseMode` selects the polarity: 0 = `phaseIn` pin, 1 = fixed 0, 2 = fixed 1, 3 = internal divider. `backplaneOut` always equals the polarity applied to the segments.
- R7: In mode 3 the internal polarity starts at 0 and toggles every `HALF_PERIOD` clocks (default 6), so it is high for exactly `HALF_PERIOD` cycles and low for exactly `HALF_PERIOD` cycles.
- R8: A change on any input that is held steady appears on the outputs at the third rising clock edge after it is applied, and not before.
- R9: Synchronous reset clears the stored code to a blank code, drives `segOut` and `backplaneOut` to 0, and clears the divider.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| digitIn | input | 4 | BCD digit, bit 3 most significant |
| latchOpen | input | 1 | High: digit follows input; falling edge captures it |
| blankIn | input | 1 | High forces all segments inactive |
| phaseIn | input | 1 | External polarity, used in mode 0 |
| phaseMode | input | 2 | Polarity source select |
| segOut | output | 7 | Segments a (bit 6) to g (bit 0) |
| backplaneOut | output | 1 | Applied polarity, for the common electrode |

## Verification
The hardest state to reach from the ports is a digit frozen while the input keeps moving. The synchronizer delay means the capture happens two clocks after the control falls, not at the pin edge. The stimulus raises the capture control with a known digit and lets it settle. It then drops the control and drives a series of different legal and illegal codes, and the outputs must still show the captured digit. A second hard case is the divider's exact duty in mode 3. Here the bench waits for a backplane rising edge and counts the clocks the backplane stays high, then the clocks it stays low.

// File: rtl/segdrv_pkg.sv
package segdrv_pkg;
  localparam int SEG_N  = 7;
  localparam int CODE_W = 4;

  typedef enum logic [1:0] {
    PH_EXT  = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2,
    PH_LCD  = 2'd3
  } phMode_e;

  typedef struct packed {
    logic loadEn;
    logic blankEn;
    logic invertEn;
  } dpStrobe_t;
endpackage

// File: rtl/segdrv_sync.sv
module segdrv_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/segdrv_ctrl.sv
module segdrv_ctrl
  import segdrv_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HALF_PERIOD = 6
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      latchOpen,
  input  logic      blankIn,
  input  logic      phaseIn,
  input  logic [1:0] phaseMode,
  output dpStrobe_t strb,
  output phMode_e   modeSync,
  output logic      lcdPhase
);
  localparam int CNT_W = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_PERIOD - 1);

  logic [4:0] rawCtl;
  logic [4:0] syncCtl;
  logic [CNT_W-1:0] halfCnt;
  logic effPhase;

  assign rawCtl = {latchOpen, blankIn, phaseIn, phaseMode};

  segdrv_sync #(.WIDTH(5), .STAGES(SYNC_STAGES)) ctlSync_i (
    .clk(clk), .rst(rst), .d(rawCtl), .q(syncCtl)
  );

  assign modeSync = phMode_e'(syncCtl[1:0]);

  always_ff @(posedge clk) begin
    if (rst || modeSync != PH_LCD) begin
      halfCnt  <= '0;
      lcdPhase <= 1'b0;
    end else if (halfCnt == CNT_LAST) begin
      halfCnt  <= '0;
      lcdPhase <= ~lcdPhase;
    end else begin
      halfCnt <= halfCnt + 1'b1;
    end
  end

  always_comb begin
    unique case (modeSync)
      PH_EXT:  effPhase = syncCtl[2];
      PH_LOW:  effPhase = 1'b0;
      PH_HIGH: effPhase = 1'b1;
      default: effPhase = lcdPhase;
    endcase
  end

  assign strb.loadEn   = syncCtl[4];
  assign strb.blankEn  = syncCtl[3];
  assign strb.invertEn = effPhase;
endmodule

// File: rtl/segdrv_dp.sv
module segdrv_dp
  import segdrv_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] digitIn,
  input  dpStrobe_t         strb,
  output logic [CODE_W-1:0] heldCode,
  output logic [CODE_W-1:0] selCode,
  output logic [SEG_N-1:0]  segOut,
  output logic              backplaneOut
);
  logic [CODE_W-1:0] digitSync;
  logic [SEG_N-1:0]  glyph;
  logic [SEG_N-1:0]  shown;
  logic [SEG_N-1:0]  segNext;

  segdrv_sync #(.WIDTH(CODE_W), .STAGES(SYNC_STAGES)) dataSync_i (
    .clk(clk), .rst(rst), .d(digitIn), .q(digitSync)
  );

  always_ff @(posedge clk) begin
    if (rst)              heldCode <= '1;
    else if (strb.loadEn) heldCode <= digitSync;
  end

  assign selCode = strb.loadEn ? digitSync : heldCode;

  always_comb begin
    unique case (selCode)
      4'd0:    glyph = 7'b1111110;
      4'd1:    glyph = 7'b0110000;
      4'd2:    glyph = 7'b1101101;
      4'd3:    glyph = 7'b1111001;
      4'd4:    glyph = 7'b0110011;
      4'd5:    glyph = 7'b1011011;
      4'd6:    glyph = 7'b1011111;
      4'd7:    glyph = 7'b1110000;
      4'd8:    glyph = 7'b1111111;
      4'd9:    glyph = 7'b1111011;
      default: glyph = 7'b0000000;
    endcase
  end

  assign shown = (strb.blankEn || selCode > 4'd9) ? '0 : glyph;

  generate
    for (genvar s = 0; s < SEG_N; s++) begin : g_pol
      assign segNext[s] = shown[s] ^ strb.invertEn;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      segOut       <= '0;
      backplaneOut <= 1'b0;
    end else begin
      segOut       <= segNext;
      backplaneOut <= strb.invertEn;
    end
  end
endmodule

// File: rtl/segdrv_top.sv
module segdrv_top
  import segdrv_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HALF_PERIOD = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] digitIn,
  input  logic       latchOpen,
  input  logic       blankIn,
  input  logic       phaseIn,
  input  logic [1:0] phaseMode,
  output logic [6:0] segOut,
  output logic       backplaneOut
);
  dpStrobe_t   strb;
  phMode_e     modeSync;
  logic        lcdPhase;
  logic [3:0]  heldCode;
  logic [3:0]  selCode;

  segdrv_ctrl #(.SYNC_STAGES(SYNC_STAGES), .HALF_PERIOD(HALF_PERIOD)) ctrl_i (
    .clk(clk), .rst(rst), .latchOpen(latchOpen), .blankIn(blankIn),
    .phaseIn(phaseIn), .phaseMode(phaseMode), .strb(strb),
    .modeSync(modeSync), .lcdPhase(lcdPhase)
  );

  segdrv_dp #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rst(rst), .digitIn(digitIn), .strb(strb),
    .heldCode(heldCode), .selCode(selCode),
    .segOut(segOut), .backplaneOut(backplaneOut)
  );
endmodule

// File: rtl/segdrv_chk.sv
module segdrv_chk
  import segdrv_pkg::*;
#(
  parameter int HALF_PERIOD = 6
) (
  input logic       clk,
  input logic       rst,
  input dpStrobe_t  strb,
  input phMode_e    modeSync,
  input logic       lcdPhase,
  input logic [3:0] heldCode,
  input logic [3:0] selCode,
  input logic [6:0] segOut,
  input logic       backplaneOut
);
  int   runLen;
  logic lastPh;

  always_ff @(posedge clk) begin
    if (rst || modeSync != PH_LCD) runLen <= 0;
    else if (lcdPhase != lastPh)   runLen <= 0;
    else                           runLen <= runLen + 1;
    lastPh <= lcdPhase;
  end

  AST_HOLD_CODE: assert property (@(posedge clk) disable iff (rst)
    !strb.loadEn |=> $stable(heldCode)); // R1
  AST_ILLEGAL_BLANK: assert property (@(posedge clk) disable iff (rst)
    selCode > 4'd9 |=> segOut == {7{backplaneOut}}); // R2
  AST_BLANK_INPUT: assert property (@(posedge clk) disable iff (rst)
    strb.blankEn |=> segOut == {7{backplaneOut}}); // R3
  AST_FIXED_LOW: assert property (@(posedge clk) disable iff (rst)
    modeSync == PH_LOW |=> !backplaneOut); // R6
  AST_FIXED_HIGH: assert property (@(posedge clk) disable iff (rst)
    modeSync == PH_HIGH |=> backplaneOut); // R6
  AST_LCD_BACKPLANE: assert property (@(posedge clk) disable iff (rst)
    modeSync == PH_LCD |=> backplaneOut == $past(lcdPhase)); // R7
  AST_LCD_RUN: assert property (@(posedge clk) disable iff (rst)
    modeSync == PH_LCD |-> runLen <= HALF_PERIOD); // R7
endmodule

bind segdrv_top segdrv_chk #(.HALF_PERIOD(HALF_PERIOD)) chk_i (
  .clk(clk), .rst(rst), .strb(strb), .modeSync(modeSync),
  .lcdPhase(lcdPhase), .heldCode(heldCode), .selCode(selCode),
  .segOut(segOut), .backplaneOut(backplaneOut)
);

// File: tb/segdrv_top_tb_top.sv
`timescale 1ns/1ps
module segdrv_top_tb_top;
  localparam int HALF = 6;

  typedef struct {
    logic [7:0] expVal;
    string      tag;
  } sbItem_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] digitIn = 4'd8;
  logic       latchOpen = 1'b0;
  logic       blankIn = 1'b0;
  logic       phaseIn = 1'b0;
  logic [1:0] phaseMode = 2'd0;
  logic [6:0] segOut;
  logic       backplaneOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [3:0] benchHeld = 4'hF;
  sbItem_t sbQ[$];

  always #2.5 clk = ~clk;

  segdrv_top #(.HALF_PERIOD(HALF)) dut_i (
    .clk(clk), .rst(rst), .digitIn(digitIn), .latchOpen(latchOpen),
    .blankIn(blankIn), .phaseIn(phaseIn), .phaseMode(phaseMode),
    .segOut(segOut), .backplaneOut(backplaneOut)
  );

  function automatic logic [6:0] refGlyph(input logic [3:0] c);
    case (c)
      4'd0: return 7'h7E;  4'd1: return 7'h30;  4'd2: return 7'h6D;
      4'd3: return 7'h79;  4'd4: return 7'h33;  4'd5: return 7'h5B;
      4'd6: return 7'h5F;  4'd7: return 7'h70;  4'd8: return 7'h7F;
      4'd9: return 7'h7B;  default: return 7'h00;
    endcase
  endfunction

  function automatic logic [7:0] refOut(input logic [3:0] c, input logic b, input logic p);
    logic [6:0] pat;
    pat = b ? 7'h00 : refGlyph(c);
    return {p, pat ^ {7{p}}};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic modePhase();
    case (phaseMode)
      2'd0: return phaseIn;
      2'd1: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic drive(input logic [3:0] c, input logic ld, input logic b, input logic p, input string tag);
    sbItem_t it;
    @(negedge clk);
    digitIn = c; latchOpen = ld; blankIn = b; phaseIn = p;
    if (ld) benchHeld = c;
    repeat (3) @(posedge clk);
    @(negedge clk);
    it.expVal = refOut(benchHeld, b, modePhase());
    it.tag = tag;
    sbQ.push_back(it);
    @(negedge clk);
  endtask

  initial begin : monitor
    sbItem_t it;
    forever begin
      wait (sbQ.size() != 0);
      it = sbQ.pop_front();
      check({backplaneOut, segOut} === it.expVal, it.tag, {backplaneOut, segOut}, it.expVal);
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    int cnt;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({backplaneOut, segOut} === 8'h00, "R9 outputs in reset", {backplaneOut, segOut}, 8'h00);
    rst = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check({backplaneOut, segOut} === 8'h00, "R9 stored code blank after reset", {backplaneOut, segOut}, 8'h00);

    // R5 R2 R3 R4: all codes with every blank and polarity combination
    for (int c = 0; c < 16; c++)
      for (int b = 0; b < 2; b++)
        for (int p = 0; p < 2; p++)
          drive(4'(c), 1'b1, 1'(b), 1'(p), $sformatf("R5/R2/R3/R4 code=%0d bi=%0d ph=%0d", c, b, p));

    // R1: capture 5, then move the input while frozen
    drive(4'd5, 1'b1, 1'b0, 1'b0, "R1 load 5");
    drive(4'd3, 1'b0, 1'b0, 1'b0, "R1 hold vs 3");
    drive(4'd8, 1'b0, 1'b0, 1'b0, "R1 hold vs 8");
    drive(4'd12, 1'b0, 1'b0, 1'b1, "R1 hold vs 12 inverted");
    drive(4'd14, 1'b0, 1'b1, 1'b0, "R1 hold under blank");
    drive(4'd2, 1'b0, 1'b0, 1'b0, "R1 hold after blank");
    drive(4'd12, 1'b1, 1'b0, 1'b0, "R1 reopen with 12");

    // R6: fixed polarity modes ignore phaseIn
    phaseMode = 2'd1;
    drive(4'd4, 1'b1, 1'b0, 1'b1, "R6 fixed low, pin high");
    phaseMode = 2'd2;
    drive(4'd4, 1'b1, 1'b0, 1'b0, "R6 fixed high, pin low");
    drive(4'd11, 1'b1, 1'b0, 1'b0, "R6 fixed high, illegal code");
    wait (sbQ.size() == 0);

    // R8: latency
    phaseMode = 2'd0;
    drive(4'd1, 1'b1, 1'b0, 1'b0, "R8 preload 1");
    wait (sbQ.size() == 0);
    @(negedge clk);
    digitIn = 4'd7;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check({backplaneOut, segOut} === 8'h30, "R8 unchanged after two edges", {backplaneOut, segOut}, 8'h30);
    @(posedge clk);
    @(negedge clk);
    check({backplaneOut, segOut} === 8'h70, "R8 updated at third edge", {backplaneOut, segOut}, 8'h70);

    // R7: internal divider duty
    digitIn = 4'd8;
    phaseMode = 2'd3;
    cnt = 0;
    while (backplaneOut !== 1'b1 && cnt < 100) begin @(negedge clk); cnt++; end
    check(segOut === 7'h00, "R7 segments inverted while backplane high", {backplaneOut, segOut}, 8'h80);
    cnt = 0;
    while (backplaneOut === 1'b1 && cnt < 100) begin @(negedge clk); cnt++; end
    check(cnt == HALF, "R7 high run length", 8'(cnt), 8'(HALF));
    check(segOut === 7'h7F, "R7 segments plain while backplane low", {backplaneOut, segOut}, 8'h7F);
    cnt = 0;
    while (backplaneOut === 1'b0 && cnt < 100) begin @(negedge clk); cnt++; end
    check(cnt == HALF, "R7 low run length", 8'(cnt), 8'(HALF));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule